// File: doc/BRIEF.md
# Wide Send Byte Packer

This block turns an 8-bit stream of bytes, read from memory for a wide data send, into 16-bit words for a two-byte-wide bus. Within a move, bytes are paired in arrival order. The earlier byte of each pair becomes the low half of the word, and the later byte becomes the high half. Each input byte carries three markers: one for the start of a move, one for the end of a move, and one that says whether the move is chained to the next.

A chained move can end on an odd byte. That byte is not sent. It stays in a low-byte holding register, and a pending flag is raised. The first byte of the next move, chained or not, becomes the high half that completes the word. This is how a run of back-to-back send moves keeps a continuous byte order on the wide bus. Every move except the last one in such a run must be chained.

An unchained move that ends on an odd byte pads the high half with a fixed value and sends the word at once. The output uses a valid/ready handshake. The input is stalled while the output register holds a word that has not been taken. The pending flag is a plain output that can be read at any time.

Top module: `wide_send_packer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `pending` is 0 and `in_ready` is 1.
- R2: Within a move, two consecutive accepted bytes form one word: the earlier byte goes in `out_data[7:0]` and the later byte in `out_data[15:8]`.
- R3: When a chained move ends on a byte that has no partner, that byte is not sent and `pending` reads 1 from the cycle after it is accepted.
- R4: A five-byte chained move that starts with `pending` at 0 produces exactly two words (bytes 1 and 2, then bytes 3 and 4), and leaves `pending` at 1.
- R5: When `pending` is 1, the next accepted byte goes in `out_data[15:8]` with the held byte in `out_data[7:0]`, and `pending` reads 0 from the next cycle.
- R6: The join of R5 happens the same way whether the new move is chained or unchained.
- R7: When an unchained move ends on a byte that has no partner, the word `{PAD_BYTE, byte}` is sent (`PAD_BYTE` is 0 by default) and `pending` stays 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` stays unchanged. Otherwise `in_ready` is 1.
- R9: A start-of-move byte that arrives while a half-filled word from an unfinished move is present (with `pending` at 0) discards that half. The new byte starts a fresh pair.
- R10: A byte that completes a word makes that word appear on `out_valid`/`out_data` in the cycle right after the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Packer can take a byte this cycle |
| in_data | input | BYTE_W | Input byte |
| in_first | input | 1 | Byte is the first of a move |
| in_last | input | 1 | Byte is the last of a move |
| in_chained | input | 1 | Move is chained (odd leftover is carried) |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 2*BYTE_W | Packed word, earlier byte in the low half |
| pending | output | 1 | A leftover byte is held for the next move |

## Verification
The packer is driven with chained moves of odd and even length, one-byte moves, a chained move followed by both an unchained and a chained move, and a move that is never closed before a new one starts. Odd chained moves separate the carry path from the pad path, and the two kinds of follow-on move show that the join does not depend on the chain marker. The unclosed move tells a carried byte apart from a stale half-word. Random move lengths and chain markers then run under random back-pressure on `out_ready`. A scoreboard built from the requirements checks every word's order, its padding, and that no byte is lost or duplicated while the output is stalled.

// File: rtl/wsp_pkg.sv
`timescale 1ns/1ps
package wsp_pkg;
   // what an accepted byte does to the pair under assembly
   typedef enum logic [1:0] {
      PK_HOLD = 2'd0,
      PK_PAIR = 2'd1,
      PK_PAD  = 2'd2
   } pack_act_e;

   function automatic int unsigned word_width(input int unsigned byte_w);
      return 2 * byte_w;
   endfunction
endpackage

// File: rtl/wsp_half_hold.sv
`timescale 1ns/1ps
module wsp_half_hold
   import wsp_pkg::*;
#(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned PAD_BYTE      = 0,
   parameter bit          ODD_FLUSH_PAD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take_i,
   input  logic [BYTE_W-1:0]     byte_i,
   input  logic                  first_i,
   input  logic                  last_i,
   input  logic                  chained_i,
   output logic                  emit_o,
   output logic [2*BYTE_W-1:0]   word_o,
   output logic                  pending_o
);
   localparam int unsigned      WORD_W = word_width(BYTE_W);
   localparam logic [BYTE_W-1:0] PAD_V = BYTE_W'(PAD_BYTE);

   logic [BYTE_W-1:0] lo_q;
   logic              half_q;
   logic              pend_q;
   logic              stale;
   logic              have_low;
   logic              flush_odd;
   pack_act_e         act;

   // a half word left by a move that never closed is dropped at a new start
   assign stale    = first_i && half_q && !pend_q;
   assign have_low = half_q && !stale;

   generate
      if (ODD_FLUSH_PAD) begin : g_flush
         assign flush_odd = last_i && !chained_i;
      end else begin : g_carry_all
         assign flush_odd = 1'b0;
      end
   endgenerate

   always_comb begin
      if (have_low)       act = PK_PAIR;
      else if (flush_odd) act = PK_PAD;
      else                act = PK_HOLD;
   end

   always_comb begin
      case (act)
         PK_PAIR: word_o = {byte_i, lo_q};
         PK_PAD:  word_o = {PAD_V, byte_i};
         default: word_o = '0;
      endcase
   end

   assign emit_o    = take_i && (act != PK_HOLD);
   assign pending_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         half_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (take_i) begin
         if (act == PK_HOLD) begin
            lo_q   <= byte_i;
            half_q <= 1'b1;
            pend_q <= last_i;
         end else begin
            half_q <= 1'b0;
            pend_q <= 1'b0;
         end
      end
   end

   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("wsp_half_hold: word width mismatch");
   end
endmodule

// File: rtl/wsp_out_stage.sv
`timescale 1ns/1ps
module wsp_out_stage #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] data_o,
   output logic              space_o
);
   logic              vq;
   logic [WORD_W-1:0] dq;

   assign space_o = !vq || ready_i;
   assign valid_o = vq;
   assign data_o  = dq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vq <= 1'b0;
         dq <= '0;
      end else if (load_i) begin
         vq <= 1'b1;
         dq <= data_i;
      end else if (ready_i) begin
         vq <= 1'b0;
      end
   end
endmodule

// File: rtl/wide_send_packer.sv
`timescale 1ns/1ps
module wide_send_packer
   import wsp_pkg::*;
#(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned PAD_BYTE      = 0,
   parameter bit          ODD_FLUSH_PAD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [BYTE_W-1:0]   in_data,
   input  logic                in_first,
   input  logic                in_last,
   input  logic                in_chained,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [2*BYTE_W-1:0] out_data,
   output logic                pending
);
   localparam int unsigned WORD_W = word_width(BYTE_W);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("wide_send_packer: BYTE_W must be at least 1");
   end
   if (BYTE_W < 32 && PAD_BYTE >= (1 << BYTE_W)) begin : g_bad_pad
      $error("wide_send_packer: PAD_BYTE does not fit in BYTE_W");
   end

   logic              take;
   logic              space;
   logic              emit;
   logic [WORD_W-1:0] word;

   assign in_ready = space;
   assign take     = in_valid && space;

   wsp_half_hold #(
      .BYTE_W        (BYTE_W),
      .PAD_BYTE      (PAD_BYTE),
      .ODD_FLUSH_PAD (ODD_FLUSH_PAD)
   ) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (take),
      .byte_i    (in_data),
      .first_i   (in_first),
      .last_i    (in_last),
      .chained_i (in_chained),
      .emit_o    (emit),
      .word_o    (word),
      .pending_o (pending)
   );

   wsp_out_stage #(
      .WORD_W (WORD_W)
   ) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (emit),
      .data_i  (word),
      .ready_i (out_ready),
      .valid_o (out_valid),
      .data_o  (out_data),
      .space_o (space)
   );
endmodule

// File: rtl/wide_send_packer_chk.sv
`timescale 1ns/1ps
module wide_send_packer_chk #(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned PAD_BYTE      = 0,
   parameter bit          ODD_FLUSH_PAD = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_first,
   input logic                in_last,
   input logic                in_chained,
   input logic                out_valid,
   input logic                out_ready,
   input logic [2*BYTE_W-1:0] out_data,
   input logic                pending
);
   localparam logic [BYTE_W-1:0] PAD_V = BYTE_W'(PAD_BYTE);
   logic take;
   assign take = in_valid && in_ready;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !pending));

   // R8
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R5
   join_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pending) |=> !pending);

   // R10
   join_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && pending) |=> out_valid);

   // R3
   carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_first && in_last && in_chained && !pending) |=> pending);

   generate
      if (ODD_FLUSH_PAD) begin : g_pad_chk
         // R7
         pad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && in_first && in_last && !in_chained && !pending) |=>
            (out_valid && out_data[2*BYTE_W-1:BYTE_W] == PAD_V && !pending));
      end
   endgenerate
endmodule

bind wide_send_packer wide_send_packer_chk #(
   .BYTE_W        (BYTE_W),
   .PAD_BYTE      (PAD_BYTE),
   .ODD_FLUSH_PAD (ODD_FLUSH_PAD)
) i_chk (.*);

// File: tb/test_wide_send_packer.sv
`timescale 1ns/1ps
module test_wide_send_packer;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [BW-1:0] in_data = '0;
   logic          in_first = 1'b0;
   logic          in_last = 1'b0;
   logic          in_chained = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [2*BW-1:0] out_data;
   logic          pending;

   always #2 clk = ~clk;

   wide_send_packer i_wide_send_packer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last),
      .in_chained(in_chained), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .pending(pending)
   );

   int checks = 0;
   int failures = 0;
   int rdy_pct = 100;
   int words_seen = 0;
   int cyc = 0;
   bit done = 0;
   bit saw_53 = 0;

   logic [2*BW-1:0] exp_q[$];
   string           tag_q[$];

   bit          m_half = 0;
   bit          m_pend = 0;
   logic [BW-1:0] m_lo = '0;
   bit          m_emitted = 0;
   logic [2*BW-1:0] m_word = '0;

   function automatic void chk(bit ok, string req, string what,
                               logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endfunction

   // reference: expected packing from the requirements
   function automatic void model_accept(logic [BW-1:0] d, bit f, bit l, bit c);
      bit have_low;
      have_low = m_half && !(f && !m_pend);
      m_emitted = 0;
      if (have_low) begin
         m_word = {d, m_lo};
         exp_q.push_back(m_word);
         tag_q.push_back(m_pend ? "R5" : "R2");
         m_emitted = 1;
         m_half = 0;
         m_pend = 0;
      end else if (l && !c) begin
         m_word = {8'h00, d};
         exp_q.push_back(m_word);
         tag_q.push_back("R7");
         m_emitted = 1;
         m_half = 0;
         m_pend = 0;
      end else begin
         m_lo = d;
         m_half = 1;
         m_pend = l;
      end
   endfunction

   // output side: random ready, scoreboard, stall checks
   bit              stalled = 0;
   logic [2*BW-1:0] stall_data = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2*BW-1:0] e;
         string t;
         if (stalled)
            chk(out_valid && out_data == stall_data, "R8", "data held in stall",
                out_data, stall_data);
         out_ready = ($urandom_range(0, 99) < rdy_pct);
         if (out_valid && out_ready) begin
            words_seen++;
            if (out_data[7:0] == 8'h53 || out_data[15:8] == 8'h53) saw_53 = 1;
            if (exp_q.size() == 0) begin
               chk(0, "R2", "unexpected word", out_data, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(out_data == e, t, "word", out_data, e);
            end
         end
         stalled = out_valid && !out_ready;
         stall_data = out_data;
      end
   end

   task automatic send(logic [BW-1:0] d, bit f, bit l, bit c);
      in_data = d; in_first = f; in_last = l; in_chained = c; in_valid = 1'b1;
      while (1) begin
         chk(in_ready == (!out_valid || out_ready), "R8", "in_ready vs stall",
             in_ready, (!out_valid || out_ready));
         if (in_ready) break;
         @(negedge clk); #1;
      end
      @(posedge clk);
      model_accept(d, f, l, c);
      @(negedge clk); #1;
      in_valid = 1'b0;
      chk(pending == m_pend, m_pend ? "R3" : "R5", "pending", pending, m_pend);
      if (m_emitted)
         chk(out_valid && out_data == m_word, "R10", "word next cycle",
             out_data, m_word);
   endtask

   task automatic move(int n, bit c);
      for (int i = 0; i < n; i++)
         send(8'($urandom), i == 0, i == n - 1, c);
   endtask

   task automatic drain();
      int lim = 0;
      rdy_pct = 100;
      while ((exp_q.size() != 0 || out_valid) && lim < 100) begin
         @(negedge clk); #1;
         lim++;
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int w0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      // R1
      chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
      chk(!pending, "R1", "pending in reset", pending, 0);
      chk(in_ready, "R1", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!out_valid && !pending && in_ready, "R1", "idle after reset",
          {out_valid, pending, in_ready}, 3'b001);

      // R4: five-byte chained move, nothing pending at the start
      rdy_pct = 100;
      w0 = words_seen;
      send(8'h11, 1, 0, 1); send(8'h12, 0, 0, 1); send(8'h13, 0, 0, 1);
      send(8'h14, 0, 0, 1); send(8'h15, 0, 1, 1);
      drain();
      chk(words_seen - w0 == 2, "R4", "words from five-byte move", words_seen - w0, 2);
      chk(pending, "R4", "pending after five-byte move", pending, 1);

      // R6: join into an unchained move, then R7 pad on its odd end
      send(8'h21, 1, 0, 0); send(8'h22, 0, 1, 0);
      drain();
      chk(!pending, "R7", "no carry after unchained move", pending, 0);

      // R6: join into a chained move
      send(8'h31, 1, 1, 1);
      send(8'h41, 1, 0, 1); send(8'h42, 0, 0, 1); send(8'h43, 0, 1, 1);
      drain();
      chk(!pending, "R6", "chained join leaves nothing", pending, 0);

      // R9: unclosed move, its half word is dropped at the next start
      send(8'h51, 1, 0, 1); send(8'h52, 0, 0, 1); send(8'h53, 0, 0, 1);
      send(8'h61, 1, 0, 0); send(8'h62, 0, 1, 0);
      drain();
      chk(!saw_53, "R9", "stale byte never sent", saw_53, 0);

      // R7: unchained odd move
      send(8'h71, 1, 0, 0); send(8'h72, 0, 0, 0); send(8'h73, 0, 1, 0);
      drain();

      // random moves under back-pressure
      for (int k = 0; k < 300; k++) begin
         rdy_pct = (k < 150) ? 60 : 25;
         move($urandom_range(1, 7), $urandom_range(0, 9) < 7);
      end
      move(1, 0);
      drain();
      chk(exp_q.size() == 0, "R2", "all expected words seen", exp_q.size(), 0);
      chk(!out_valid, "R8", "output empty at end", out_valid, 0);

      done = 1;
      finish_run();
   end
endmodule